// File: doc/BRIEF.md
# Channel Threshold-Search Conversion Sequencer

This block runs an analog-to-digital conversion on a part that has only a 7-bit threshold DAC and one comparator per channel. It reaches that part through a byte-wide serial link. The block writes DAC-load bytes to an SPI master engine over a request/complete handshake. After each transfer it reads the status byte that comes back, and it takes the comparator bit of the selected channel from that byte. The design has to allow for one fact about the part: the comparator bit in a returned byte judges the DAC value from the write before it, not the value loaded by the write that returns the byte.

There are two modes. A full conversion is a binary search over seven trials, most significant bit first, and it returns a 7-bit code. The go/no-go mode loads one programmed limit and reports whether the channel is above it. A trial code is never allowed to fall to zero, because a zero code shuts the DAC and the comparators down. Trial codes are also kept inside the usable threshold window. When the result is ready, the block pulses a done strobe for one cycle and holds the code, the underrange flag and the pass flag until the next result.

Top module: `chan_sar_seq`

## Requirements
- R1: Every byte sent on `xfer_tx_o` is a DAC load: bit 7 is 1 and bits 6:0 carry the DAC code.
- R2: No DAC code sent is below 20. A trial or limit value below 20 is sent as 20, so code zero is never sent.
- R3: A full conversion tests code bits from bit 6 down to bit 0. The bit under test is kept when the comparator reports 1, which means the channel is above the threshold. The final raw code is the largest D in 0..127 with D times the step below the channel voltage, where the step is 10 mV for channels 0 and 2 and 40 mV for channel 1.
- R4: The verdict on a trial comes from the status returned by the transfer after the one that loaded it. Each trial is sent twice in a row with the same byte, and only the second returned status is used. A full conversion uses exactly 14 transfers.
- R5: The verdict bit in the returned status is bit 5 for channel 0, bit 6 for channel 1 and bit 7 for channel 2. Bits 4:0 and the bits of the other channels have no effect.
- R6: When a conversion's raw code is below 20, `code_o` reports 20 and `under_o` is 1. Otherwise `code_o` equals the raw code and `under_o` is 0.
- R7: Go/no-go mode sends the limit, floored at 20, in exactly 2 transfers. It reports `pass_o` equal to the channel's comparator bit from the second returned status, with `code_o` set to the floored limit and `under_o` 0. A full conversion reports `pass_o` 0.
- R8: `done_o` is high for exactly one cycle per result. `code_o`, `under_o` and `pass_o` change only in that cycle and hold their values in between.
- R9: A start request seen while a conversion or go/no-go check is in progress is ignored. It neither starts a second run nor changes the result of the run in progress.
- R10: A start request with channel select 3 is ignored and issues no transfer.
- R11: After reset, `xfer_req_o`, `done_o`, `code_o`, `under_o` and `pass_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin a run |
| limit_mode_i | input | 1 | 1 selects go/no-go, 0 selects full conversion (sampled with start) |
| chan_i | input | 2 | Channel to measure, 0 to 2 (sampled with start) |
| limit_i | input | 7 | Limit code for go/no-go (sampled with start) |
| xfer_req_o | output | 1 | One-cycle request to the SPI engine to send `xfer_tx_o` |
| xfer_tx_o | output | 8 | Byte to send, a DAC load |
| xfer_done_i | input | 1 | One-cycle completion from the SPI engine |
| xfer_rx_i | input | 8 | Status byte returned with the completion |
| code_o | output | 7 | Result code |
| done_o | output | 1 | One-cycle result strobe |
| pass_o | output | 1 | Go/no-go result, 1 when the channel is above the limit |
| under_o | output | 1 | Conversion result hit the floor of the threshold range |

## Verification
The bench's device model always answers with the verdict on the previous DAC load. A design that decided each trial from the status of its own load transfer would therefore produce codes that are off by the stale verdicts, and the bench targets that fault. Voltages just above and just at a threshold step (1270 mV against 127 steps, 3000 mV against a 40 mV step) expose an off-by-one in the keep/drop decision, and a mix of channel voltages exposes a wrong status-bit selection. Inputs below 200 mV and at 205 mV separate a design that sends zero or forgets the floor from one that sets the underrange flag at the wrong boundary. Start requests during a run and on channel 3 catch a design that restarts, corrupts the run in progress, or sends bytes for a channel that does not exist.

// File: rtl/csar_pkg.sv
package csar_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_LOAD_REQ = 3'd1,
        ST_LOAD_WT  = 3'd2,
        ST_COL_REQ  = 3'd3,
        ST_COL_WT   = 3'd4
    } seq_st_e;

endpackage

// File: rtl/csar_load_fmt.sv
// Builds a DAC-load byte from a raw trial code, raising it to the floor code.
module csar_load_fmt #(
    parameter int CW       = 7,
    parameter int MIN_CODE = 20
) (
    input  logic [CW-1:0] raw_i,
    output logic [CW:0]   byte_o
);
    localparam logic [CW-1:0] FLOOR = CW'(MIN_CODE);

    always_comb begin
        byte_o = {1'b1, (raw_i < FLOOR) ? FLOOR : raw_i};
    end
endmodule

// File: rtl/csar_verdict.sv
// Picks the comparator bit of the selected channel out of a returned status byte.
module csar_verdict #(
    parameter int BW        = 8,
    parameter int CHW       = 2,
    parameter int N_CH      = 3,
    parameter int FIRST_BIT = 5
) (
    input  logic [BW-1:0]  rx_i,
    input  logic [CHW-1:0] ch_i,
    output logic           hit_o
);
    logic [N_CH-1:0] ch_bits;
    logic            unused_low;

    genvar gi;
    generate
        for (gi = 0; gi < N_CH; gi++) begin : g_bit
            assign ch_bits[gi] = rx_i[FIRST_BIT + gi];
        end
        if (FIRST_BIT > 0) begin : g_low
            assign unused_low = ^rx_i[FIRST_BIT-1:0];
        end else begin : g_nolow
            assign unused_low = 1'b0;
        end
    endgenerate

    always_comb begin
        hit_o = 1'b0;
        for (int k = 0; k < N_CH; k++) begin
            if (ch_i == CHW'(k)) hit_o = ch_bits[k];
        end
    end
endmodule

// File: rtl/chan_sar_seq.sv
module chan_sar_seq
    import csar_pkg::*;
#(
    parameter int CODE_W    = 7,
    parameter int CH_W      = 2,
    parameter int N_CH      = 3,
    parameter int FIRST_BIT = 5,
    parameter int MIN_CODE  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              limit_mode_i,
    input  logic [CH_W-1:0]   chan_i,
    input  logic [CODE_W-1:0] limit_i,
    output logic              xfer_req_o,
    output logic [CODE_W:0]   xfer_tx_o,
    input  logic              xfer_done_i,
    input  logic [CODE_W:0]   xfer_rx_i,
    output logic [CODE_W-1:0] code_o,
    output logic              done_o,
    output logic              pass_o,
    output logic              under_o
);
    localparam int               BP_W  = $clog2(CODE_W);
    localparam logic [CODE_W-1:0] FLOOR = CODE_W'(MIN_CODE);

    typedef struct packed {
        seq_st_e           st;
        logic              lim;
        logic [CH_W-1:0]   ch;
        logic [CODE_W-1:0] acc;
        logic [BP_W-1:0]   bpos;
        logic [CODE_W-1:0] lim_code;
        logic [CODE_W-1:0] code;
        logic              pass;
        logic              under;
        logic              done;
    } ctl_t;

    ctl_t              ctl_q, ctl_d;
    logic [CODE_W-1:0] raw_trial;
    logic [CODE_W-1:0] acc_next;
    logic [CODE_W:0]   load_byte;
    logic              hit;

    always_comb begin
        raw_trial = ctl_q.lim ? ctl_q.lim_code
                              : (ctl_q.acc | (CODE_W'(1) << ctl_q.bpos));
    end

    csar_load_fmt #(.CW(CODE_W), .MIN_CODE(MIN_CODE)) u_fmt (
        .raw_i  (raw_trial),
        .byte_o (load_byte)
    );

    csar_verdict #(.BW(CODE_W + 1), .CHW(CH_W), .N_CH(N_CH), .FIRST_BIT(FIRST_BIT)) u_verdict (
        .rx_i  (xfer_rx_i),
        .ch_i  (ctl_q.ch),
        .hit_o (hit)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        acc_next   = hit ? raw_trial : ctl_q.acc;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_i && (chan_i < CH_W'(N_CH))) begin
                    ctl_d.st       = ST_LOAD_REQ;
                    ctl_d.lim      = limit_mode_i;
                    ctl_d.ch       = chan_i;
                    ctl_d.acc      = '0;
                    ctl_d.bpos     = BP_W'(CODE_W - 1);
                    ctl_d.lim_code = limit_i;
                end
            end
            ST_LOAD_REQ: ctl_d.st = ST_LOAD_WT;
            ST_LOAD_WT: begin
                // status of this transfer judges the previous load: discard it
                if (xfer_done_i) ctl_d.st = ST_COL_REQ;
            end
            ST_COL_REQ: ctl_d.st = ST_COL_WT;
            ST_COL_WT: begin
                if (xfer_done_i) begin
                    if (ctl_q.lim) begin
                        ctl_d.code  = load_byte[CODE_W-1:0];
                        ctl_d.pass  = hit;
                        ctl_d.under = 1'b0;
                        ctl_d.done  = 1'b1;
                        ctl_d.st    = ST_IDLE;
                    end else if (ctl_q.bpos == '0) begin
                        ctl_d.acc   = acc_next;
                        ctl_d.code  = (acc_next < FLOOR) ? FLOOR : acc_next;
                        ctl_d.under = acc_next < FLOOR;
                        ctl_d.pass  = 1'b0;
                        ctl_d.done  = 1'b1;
                        ctl_d.st    = ST_IDLE;
                    end else begin
                        ctl_d.acc  = acc_next;
                        ctl_d.bpos = ctl_q.bpos - BP_W'(1);
                        ctl_d.st   = ST_LOAD_REQ;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign xfer_req_o = (ctl_q.st == ST_LOAD_REQ) || (ctl_q.st == ST_COL_REQ);
    assign xfer_tx_o  = load_byte;
    assign code_o     = ctl_q.code;
    assign done_o     = ctl_q.done;
    assign pass_o     = ctl_q.pass;
    assign under_o    = ctl_q.under;

    AST_LOAD_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req_o |-> xfer_tx_o[CODE_W]); // R1
    AST_TRIAL_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req_o |-> (xfer_tx_o[CODE_W-1:0] >= FLOOR)); // R2
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req_o |=> !xfer_req_o); // R4
    AST_UNDER_AT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        under_o |-> (code_o == FLOOR)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(code_o) && $stable(pass_o) && $stable(under_o))); // R8
    AST_NO_REQ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !xfer_req_o); // R9
endmodule

// File: tb/chan_sar_seq_bench.sv
module chan_sar_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       limit_mode_i = 1'b0;
    logic [1:0] chan_i = 2'd0;
    logic [6:0] limit_i = 7'd0;
    logic       xfer_req_o;
    logic [7:0] xfer_tx_o;
    logic       xfer_done_i = 1'b0;
    logic [7:0] xfer_rx_i = 8'h00;
    logic [6:0] code_o;
    logic       done_o;
    logic       pass_o;
    logic       under_o;

    always #5 clk = ~clk;

    chan_sar_seq u_chan_sar_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .limit_mode_i (limit_mode_i),
        .chan_i       (chan_i),
        .limit_i      (limit_i),
        .xfer_req_o   (xfer_req_o),
        .xfer_tx_o    (xfer_tx_o),
        .xfer_done_i  (xfer_done_i),
        .xfer_rx_i    (xfer_rx_i),
        .code_o       (code_o),
        .done_o       (done_o),
        .pass_o       (pass_o),
        .under_o      (under_o)
    );

    typedef struct {
        logic [6:0] code;
        logic       under;
        logic       pass;
        int         nx;
        int         base;
        string      tag;
    } exp_t;

    exp_t sbq[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    int   mv[3];
    int   xfer_cnt = 0;
    int   done_cnt = 0;
    logic [6:0] prev_dac = 7'd0;
    logic [7:0] last_tx = 8'h00;
    logic       lowbat = 1'b0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] status_for(input logic [6:0] d);
        logic [7:0] s;
        s = {3'b000, lowbat, 4'b1010};
        if (d != 7'd0) begin
            s[7] = mv[2] > int'(d) * 10;
            s[6] = mv[1] > int'(d) * 40;
            s[5] = mv[0] > int'(d) * 10;
        end
        return s;
    endfunction

    // device model behind the SPI engine: the verdict always judges the previous load
    initial begin
        forever begin
            @(negedge clk);
            xfer_done_i = 1'b0;
            if (xfer_req_o) begin
                chk(xfer_tx_o[7] == 1'b1, "R1", "load marker bit", xfer_tx_o[7], 1);
                chk(xfer_tx_o[6:0] >= 7'd20, "R2", "sent code floor", xfer_tx_o[6:0], 20);
                if (xfer_cnt % 2 == 1)
                    chk(xfer_tx_o == last_tx, "R4", "collect byte repeats load", xfer_tx_o, last_tx);
                last_tx = xfer_tx_o;
                xfer_cnt++;
                repeat (2) @(negedge clk);
                xfer_rx_i   = status_for(prev_dac);
                prev_dac    = last_tx[6:0];
                lowbat      = ~lowbat;
                xfer_done_i = 1'b1;
            end
        end
    end

    // scoreboard monitor
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (done_o) begin
                done_cnt++;
                if (sbq.size() == 0) begin
                    chk(1'b0, "R9", "unexpected done", 1, 0);
                end else begin
                    e = sbq.pop_front();
                    chk(code_o == e.code, e.tag, "code", code_o, e.code);
                    chk(under_o == e.under, e.tag, "underrange", under_o, e.under);
                    chk(pass_o == e.pass, e.tag, "pass", pass_o, e.pass);
                    chk(xfer_cnt - e.base == e.nx, e.nx == 2 ? "R7" : "R4",
                        "transfer count", xfer_cnt - e.base, e.nx);
                end
                @(negedge clk);
                chk(done_o == 1'b0, "R8", "done width", done_o, 0);
            end
        end
    end

    task automatic run(input int ch, input bit lim, input int limit, input string tag);
        exp_t e;
        int   step;
        int   t;
        int   l;
        step = (ch == 1) ? 40 : 10;
        t = 0;
        if (lim) begin
            l = (limit < 20) ? 20 : limit;
            e.code  = 7'(l);
            e.under = 1'b0;
            e.pass  = mv[ch] > l * step;
            e.nx    = 2;
        end else begin
            for (int d = 1; d < 128; d++) if (d * step < mv[ch]) t = d;
            e.code  = (t < 20) ? 7'd20 : 7'(t);
            e.under = t < 20;
            e.pass  = 1'b0;
            e.nx    = 14;
        end
        e.base = xfer_cnt;
        e.tag  = tag;
        sbq.push_back(e);
        @(negedge clk);
        chan_i = 2'(ch); limit_mode_i = lim; limit_i = 7'(limit); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (sbq.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int xs;
        int ds;
        mv[0] = 555; mv[1] = 3000; mv[2] = 1300;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(xfer_req_o == 0, "R11", "reset req", xfer_req_o, 0);
        chk(done_o == 0, "R11", "reset done", done_o, 0);
        chk(code_o == 0, "R11", "reset code", code_o, 0);
        chk(under_o == 0 && pass_o == 0, "R11", "reset flags", {under_o, pass_o}, 0);

        run(0, 0, 0, "R3 ch0 555mV");
        repeat (20) @(negedge clk);
        chk(code_o == 7'd55, "R8", "code held after done", code_o, 55);
        mv[0] = 640;  run(0, 0, 0, "R3 ch0 640mV");
        run(2, 0, 0, "R3 ch2 saturate");
        mv[2] = 1270; run(2, 0, 0, "R3 ch2 1270mV");
        run(1, 0, 0, "R3 ch1 3000mV");
        mv[0] = 150;  run(0, 0, 0, "R6 ch0 below floor");
        mv[0] = 205;  run(0, 0, 0, "R6 ch0 at floor");
        mv[0] = 1000; mv[1] = 900; mv[2] = 100;
        run(1, 0, 0, "R5 ch1 isolation");
        run(0, 0, 0, "R5 ch0 isolation");
        run(2, 0, 0, "R5 ch2 isolation");
        mv[2] = 900;  run(2, 1, 80, "R7 limit pass");
        mv[2] = 790;  run(2, 1, 80, "R7 limit fail");
        mv[0] = 210;  run(0, 1, 5, "R7 limit floored");
        mv[1] = 2000; run(1, 1, 50, "R7 limit equal");

        // R9: start during a run is ignored
        mv[0] = 777;
        begin
            exp_t e;
            e.code = 7'd77; e.under = 1'b0; e.pass = 1'b0; e.nx = 14;
            e.base = xfer_cnt; e.tag = "R9 busy start";
            sbq.push_back(e);
        end
        ds = done_cnt;
        @(negedge clk);
        chan_i = 2'd0; limit_mode_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (10) @(negedge clk);
        chan_i = 2'd2; limit_mode_i = 1'b1; limit_i = 7'd30; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (sbq.size() != 0) @(negedge clk);
        repeat (100) @(negedge clk);
        chk(done_cnt - ds == 1, "R9", "results after busy start", done_cnt - ds, 1);

        // R10: channel 3 ignored
        xs = xfer_cnt;
        ds = done_cnt;
        @(negedge clk);
        chan_i = 2'd3; limit_mode_i = 1'b0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (60) @(negedge clk);
        chk(xfer_cnt == xs, "R10", "transfers for channel 3", xfer_cnt - xs, 0);
        chk(done_cnt == ds, "R10", "results for channel 3", done_cnt - ds, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule